// File: doc/BRIEF.md
# Lane Activity Mask Decoder

This block sits on the receiving end of a multi-lane streaming link. Each transfer carries N data lanes, a first-lane index, a last-lane index and a lane-enable strobe. A compile-time tier parameter sets the strobe width. Below tier 7 the strobe is one bit that covers the whole transfer. From tier 7 upward it has one bit per lane.

For every accepted transfer, the block works out which lanes hold live data. It sends that result out as one per-lane mask, alongside the unchanged data, through a single registered valid/ready slice. Logic further downstream therefore sees the same mask format whatever tier the source was built for.

The block also flags transfers whose mask comes out all zero, and transfers whose indices are reversed while those indices are meaningful.

Top module: `lane_mask_decoder`

## Requirements
- R1: Below tier 7, a transfer whose single strobe bit is 0 produces an all-zero mask and no error, whatever values the two indices carry.
- R2: Below tier 7, a transfer whose strobe bit is 1 and whose first index is not above its last index produces a mask with bit i (lane i) set exactly for first ≤ i ≤ last.
- R3: At tier 7 or above, when every strobe bit is 1 and first ≤ last, the mask has bit i set exactly for first ≤ i ≤ last.
- R4: At tier 7 or above, when any strobe bit is 0, the mask equals the strobe vector (bit i = lane i), the indices are ignored, and no error is raised.
- R5: When the indices are meaningful (the strobe bit is 1 below tier 7, or all strobe bits are 1 at tier 7 or above) and first > last, the error output is 1 and the mask is all zero.
- R6: The empty output equals 1 exactly when the mask sent with it is all zero.
- R7: While the output is valid and not ready, the data, mask, empty and error outputs and the valid output stay unchanged.
- R8: The input-ready output is 1 whenever the output slice is empty or the output is ready. Reset clears the output valid in the next cycle.
- R9: The data lanes of an accepted transfer appear unchanged on the output one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Input transfer valid |
| in_ready_o | output | 1 | Input transfer accepted when high with valid |
| in_data_i | input | N_LANES*LANE_W | Lane data, lane 0 in the low bits |
| first_lane_i | input | IDX_W | First lane index |
| last_lane_i | input | IDX_W | Last lane index, inclusive |
| lane_en_i | input | 1 if TIER<7, else N_LANES | Strobe: whole transfer, or per lane |
| out_valid_o | output | 1 | Output valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | N_LANES*LANE_W | Registered lane data |
| out_mask_o | output | N_LANES | Resolved per-lane active mask |
| out_empty_o | output | 1 | Mask is all zero |
| out_proterr_o | output | 1 | Reversed significant indices |

## Verification
Two instances run side by side on the same stimulus, one at tier 7 and one at tier 3. Each pattern therefore shows how the two tiers diverge.

The table contains:
- a full strobe with a full range and with a narrowed range, which separates R2/R3 range decoding from plain strobe copying;
- partial strobes with narrowed indices, where the tiers disagree: one copies the strobe, the other uses lane 0 alone to gate a range;
- reversed indices under a full strobe and under a partial strobe, which separates a real error from ignored indices.

Directed tests then hold the output under backpressure while a second transfer waits, and check the reset state.

// File: rtl/lmd_pkg.sv
package lmd_pkg;

  // Lowest tier at which the strobe carries one bit per lane.
  localparam int PER_LANE_TIER = 7;

  // How a transfer's active lanes were decided.
  typedef enum logic [1:0] {
    RES_EMPTY  = 2'd0,
    RES_RANGE  = 2'd1,
    RES_STROBE = 2'd2,
    RES_BAD    = 2'd3
  } res_kind_e;

endpackage

// File: rtl/lmd_range_mask.sv
module lmd_range_mask #(
  parameter int N_LANES = 4,
  parameter int IDX_W   = 2
) (
  input  logic [IDX_W-1:0]   first_i,
  input  logic [IDX_W-1:0]   last_i,
  output logic [N_LANES-1:0] mask_o,
  output logic               reversed_o
);

  // One comparator pair per lane.
  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    localparam logic [IDX_W-1:0] LANE_IDX = IDX_W'(g);
    assign mask_o[g] = (LANE_IDX >= first_i) && (LANE_IDX <= last_i);
  end

  assign reversed_o = first_i > last_i;

endmodule

// File: rtl/lmd_resolve.sv
module lmd_resolve
  import lmd_pkg::*;
#(
  parameter int N_LANES = 4,
  parameter int IDX_W   = 2,
  parameter int TIER    = 7,
  parameter int EN_W    = 4
) (
  input  logic [IDX_W-1:0]   first_i,
  input  logic [IDX_W-1:0]   last_i,
  input  logic [EN_W-1:0]    lane_en_i,
  output logic [N_LANES-1:0] mask_o,
  output logic               err_o,
  output logic               empty_o
);

  logic [N_LANES-1:0] range_mask;
  logic               reversed;
  res_kind_e          kind;

  lmd_range_mask #(
    .N_LANES(N_LANES),
    .IDX_W  (IDX_W)
  ) u_range (
    .first_i   (first_i),
    .last_i    (last_i),
    .mask_o    (range_mask),
    .reversed_o(reversed)
  );

  if (TIER >= PER_LANE_TIER) begin : g_per_lane
    // Indices count only when every lane strobe is set.
    always_comb begin
      if (!(&lane_en_i)) kind = RES_STROBE;
      else if (reversed)  kind = RES_BAD;
      else                kind = RES_RANGE;
    end
    always_comb begin
      case (kind)
        RES_STROBE: mask_o = lane_en_i;
        RES_RANGE:  mask_o = range_mask;
        default:    mask_o = '0;
      endcase
    end
  end else begin : g_single
    // A cleared single strobe means an empty transfer.
    always_comb begin
      if (!lane_en_i[0]) kind = RES_EMPTY;
      else if (reversed) kind = RES_BAD;
      else               kind = RES_RANGE;
    end
    always_comb begin
      if (kind == RES_RANGE) mask_o = range_mask;
      else                   mask_o = '0;
    end
  end

  assign err_o   = (kind == RES_BAD);
  assign empty_o = (mask_o == '0);

endmodule

// File: rtl/lmd_out_slice.sv
module lmd_out_slice #(
  parameter int PAY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [PAY_W-1:0] in_pay_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [PAY_W-1:0] out_pay_o
);

  logic             vld_q;
  logic [PAY_W-1:0] pay_q;

  assign in_ready_o = !vld_q || out_ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
    end else if (in_ready_o) begin
      vld_q <= in_valid_i;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid_i && in_ready_o) pay_q <= in_pay_i;
  end

  assign out_valid_o = vld_q;
  assign out_pay_o   = pay_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !out_ready_i) |=> (vld_q && $stable(pay_q))) else $error("hold"); // R7

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !vld_q) else $error("reset idle"); // R8

  AST_READY_FREE: assert property (@(posedge clk) disable iff (rst)
    !vld_q |-> in_ready_o) else $error("ready when empty"); // R8

endmodule

// File: rtl/lane_mask_decoder.sv
module lane_mask_decoder
  import lmd_pkg::*;
#(
  parameter int N_LANES = 4,
  parameter int LANE_W  = 8,
  parameter int TIER    = 7,
  localparam int IDX_W  = (N_LANES > 1) ? $clog2(N_LANES) : 1,
  localparam int EN_W   = (TIER >= PER_LANE_TIER) ? N_LANES : 1,
  localparam int DATA_W = N_LANES * LANE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [DATA_W-1:0]  in_data_i,
  input  logic [IDX_W-1:0]   first_lane_i,
  input  logic [IDX_W-1:0]   last_lane_i,
  input  logic [EN_W-1:0]    lane_en_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [DATA_W-1:0]  out_data_o,
  output logic [N_LANES-1:0] out_mask_o,
  output logic               out_empty_o,
  output logic               out_proterr_o
);

  localparam int PAY_W = DATA_W + N_LANES + 2;

  logic [N_LANES-1:0] res_mask;
  logic               res_err;
  logic               res_empty;
  logic [PAY_W-1:0]   pay_in;
  logic [PAY_W-1:0]   pay_out;

  lmd_resolve #(
    .N_LANES(N_LANES),
    .IDX_W  (IDX_W),
    .TIER   (TIER),
    .EN_W   (EN_W)
  ) u_resolve (
    .first_i  (first_lane_i),
    .last_i   (last_lane_i),
    .lane_en_i(lane_en_i),
    .mask_o   (res_mask),
    .err_o    (res_err),
    .empty_o  (res_empty)
  );

  assign pay_in = {in_data_i, res_mask, res_empty, res_err};

  lmd_out_slice #(
    .PAY_W(PAY_W)
  ) u_slice (
    .clk        (clk),
    .rst        (rst),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .in_pay_i   (pay_in),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .out_pay_o  (pay_out)
  );

  assign {out_data_o, out_mask_o, out_empty_o, out_proterr_o} = pay_out;

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && out_proterr_o) |-> (out_mask_o == '0)) else $error("err mask"); // R5

  AST_EMPTY_MATCH: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> (out_empty_o == (out_mask_o == '0))) else $error("empty"); // R6

  if (TIER >= PER_LANE_TIER) begin : g_chk_hi
    AST_STROBE_PASS: assert property (@(posedge clk) disable iff (rst)
      (in_valid_i && in_ready_o && !(&lane_en_i)) |=>
        (out_mask_o == $past(lane_en_i) && !out_proterr_o)) else $error("strobe"); // R4
  end else begin : g_chk_lo
    AST_LOW_STROBE_EMPTY: assert property (@(posedge clk) disable iff (rst)
      (in_valid_i && in_ready_o && !lane_en_i[0]) |=>
        (out_mask_o == '0 && out_empty_o && !out_proterr_o)) else $error("low strobe"); // R1
  end

endmodule

// File: tb/test_lane_mask_decoder.sv
module test_lane_mask_decoder;

  localparam int N  = 4;
  localparam int LW = 8;
  localparam int DW = N * LW;
  localparam int NV = 10;

  // {first[2], last[2], strobe[4], hi mask[4], hi err, lo mask[4], lo err}
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 2'd3, 4'b1111, 4'b1111, 1'b0, 4'b1111, 1'b0}, // R2 R3 full range
    {2'd1, 2'd2, 4'b1111, 4'b0110, 1'b0, 4'b0110, 1'b0}, // R2 R3 narrowed
    {2'd0, 2'd0, 4'b1010, 4'b1010, 1'b0, 4'b0000, 1'b0}, // R1 R4
    {2'd0, 2'd0, 4'b1011, 4'b1011, 1'b0, 4'b0001, 1'b0}, // R2 R4
    {2'd3, 2'd1, 4'b1111, 4'b0000, 1'b1, 4'b0000, 1'b1}, // R5 both tiers
    {2'd3, 2'd1, 4'b0110, 4'b0110, 1'b0, 4'b0000, 1'b0}, // R4 R1 reversed ignored
    {2'd2, 2'd2, 4'b0000, 4'b0000, 1'b0, 4'b0000, 1'b0}, // R4 R1 R6
    {2'd3, 2'd3, 4'b0001, 4'b0001, 1'b0, 4'b1000, 1'b0}, // R2 R4
    {2'd2, 2'd3, 4'b1101, 4'b1101, 1'b0, 4'b1100, 1'b0}, // R2 R4
    {2'd1, 2'd0, 4'b0001, 4'b0001, 1'b0, 4'b0000, 1'b1}  // R4 R5
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [DW-1:0] in_data = '0;
  logic [1:0] first_l = '0;
  logic [1:0] last_l = '0;
  logic [N-1:0] en = '0;

  logic hi_in_ready, hi_valid, hi_empty, hi_err;
  logic lo_in_ready, lo_valid, lo_empty, lo_err;
  logic [DW-1:0] hi_data, lo_data;
  logic [N-1:0] hi_mask, lo_mask;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lane_mask_decoder #(.N_LANES(N), .LANE_W(LW), .TIER(7)) i_lane_mask_decoder (
    .clk(clk), .rst(rst), .in_valid_i(in_valid), .in_ready_o(hi_in_ready),
    .in_data_i(in_data), .first_lane_i(first_l), .last_lane_i(last_l),
    .lane_en_i(en), .out_valid_o(hi_valid), .out_ready_i(out_ready),
    .out_data_o(hi_data), .out_mask_o(hi_mask), .out_empty_o(hi_empty),
    .out_proterr_o(hi_err));

  lane_mask_decoder #(.N_LANES(N), .LANE_W(LW), .TIER(3)) i_lane_mask_decoder_lo (
    .clk(clk), .rst(rst), .in_valid_i(in_valid), .in_ready_o(lo_in_ready),
    .in_data_i(in_data), .first_lane_i(first_l), .last_lane_i(last_l),
    .lane_en_i(en[0]), .out_valid_o(lo_valid), .out_ready_i(out_ready),
    .out_data_o(lo_data), .out_mask_o(lo_mask), .out_empty_o(lo_empty),
    .out_proterr_o(lo_err));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [17:0] v, input logic [DW-1:0] d);
    first_l  = v[17:16];
    last_l   = v[15:14];
    en       = v[13:10];
    in_data  = d;
    in_valid = 1'b1;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] da, db;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 reset valid hi", 32'(hi_valid), 32'd0);
    chk("R8 reset valid lo", 32'(lo_valid), 32'd0);
    chk("R8 reset ready", 32'({hi_in_ready, lo_in_ready}), 32'd3);

    for (int k = 0; k < NV; k++) begin
      logic [DW-1:0] d;
      d = 32'hA1B2C3D4 ^ 32'(k * 32'h01010101);
      drive(VEC[k], d);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R8 valid after accept", 32'({hi_valid, lo_valid}), 32'd3);
      chk("R3 or R4 hi mask", 32'(hi_mask), 32'(VEC[k][9:6]));
      chk("R5 hi err", 32'(hi_err), 32'(VEC[k][5]));
      chk("R6 hi empty", 32'(hi_empty), 32'(VEC[k][9:6] == 4'd0));
      chk("R1 or R2 lo mask", 32'(lo_mask), 32'(VEC[k][4:1]));
      chk("R5 lo err", 32'(lo_err), 32'(VEC[k][0]));
      chk("R6 lo empty", 32'(lo_empty), 32'(VEC[k][4:1] == 4'd0));
      chk("R9 hi data", hi_data, d);
      chk("R9 lo data", lo_data, d);
    end

    // R7 backpressure: A sits on output, B waits at the input.
    @(negedge clk);
    out_ready = 1'b0;
    da = 32'h11223344;
    db = 32'h55667788;
    drive(VEC[1], da);
    @(negedge clk);
    drive(VEC[2], db);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk("R8 ready low under stall", 32'({hi_in_ready, lo_in_ready}), 32'd0);
      chk("R7 valid held", 32'({hi_valid, lo_valid}), 32'd3);
      chk("R7 data held", hi_data, da);
      chk("R7 hi mask held", 32'(hi_mask), 32'b0110);
      chk("R7 lo mask held", 32'(lo_mask), 32'b0110);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 next after release", hi_data, db);
    chk("R4 hi mask of B", 32'(hi_mask), 32'b1010);
    chk("R1 lo mask of B", 32'(lo_mask), 32'b0000);
    @(negedge clk);
    chk("R8 drains", 32'({hi_valid, lo_valid}), 32'd0);

    // R8 reset while output valid.
    drive(VEC[0], da);
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk("R8 reset clears valid", 32'({hi_valid, lo_valid}), 32'd0);
    rst = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule